// File: doc/BRIEF.md
# Bit-Serial Packet Accumulator Element

This element sits in a one-bit-wide stream of execution packets and carries out a single arithmetic step on each packet that passes it. A packet opens with a fixed-length header and a 4-bit opcode. Next come four 32-bit operands, called lanes A, B, C and D, whose bits are interleaved one bit position at a time. A fixed-length tail closes the packet. When the opcode names the function selected on the element's control pin, the element computes its result one bit at a time and writes each result bit into the lane-A slot of the outgoing stream. Lane A acts as the accumulator. Every other bit leaves exactly as it arrived. Packets for any other opcode pass through untouched.

Both stream edges use a valid/ready handshake, one bit per transfer. A bit moves when valid and ready are high on the same rising clock edge. The source must hold the bit and its start flag stable while valid is high and ready is low. The element holds its output bit the same way while the sink keeps ready low. A two-stage bit pipeline decouples the two edges.

The lane-A bit of position i arrives one bit before the lane-B bit of the same position. A lane-A slot of a matching packet is therefore held back until its lane-B partner is inside the element. Add carries ripple through a single flip-flop from one bit position to the next. That flip-flop is cleared while the opcode field is leaving the element.

Top module: `bsp_accum_elem`

## Requirements
- R1: While reset is applied and in the cycle after it is released, `out_valid` is low and `in_ready` is high.
- R2: Packet layout in bit order, with the first bit flagged by `in_sof`:
  - HDR_BITS header bits (default 8);
  - 4 opcode bits, least significant first;
  - 128 operand bits, ordered by bit position from the LSB, and within each position lane A, then B, then C, then D;
  - TAIL_BITS tail bits (default 8).
  
  The output repeats the same bit count and order, and `out_sof` is high on exactly the output bit that entered with `in_sof`.
- R3: With `func_sel` = 0 the element matches opcode 4'h3 (add). The lane-A slots of a matching packet leave carrying the bits of (A + B) mod 2^32.
- R4: With `func_sel` = 1 the element matches opcode 4'h6 (xor). The lane-A slots of a matching packet leave carrying A ^ B.
- R5: The add carry starts from zero in every packet. A carry out of bit 31 of one packet has no effect on the next packet's result.
- R6: In a matching packet, the header, opcode, lane-B, lane-C, lane-D and tail bits leave unchanged.
- R7: A packet whose opcode differs from the one selected by `func_sel` leaves with every bit unchanged.
- R8: While `out_valid` is high and `out_ready` is low, `out_bit` and `out_sof` stay stable. `in_ready` falls only when both pipeline stages are full and the output is not draining, so at most two bits are taken while the output is stalled. No bit is lost or duplicated under any pattern of valid gaps and ready stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| func_sel | input | 1 | Function of this element: 0 add, 1 xor; must be stable while a packet's opcode enters |
| in_valid | input | 1 | Input bit is valid |
| in_ready | output | 1 | Element can take an input bit |
| in_bit | input | 1 | Serial input data |
| in_sof | input | 1 | Marks the first header bit of a packet |
| out_valid | output | 1 | Output bit is valid |
| out_ready | input | 1 | Sink can take an output bit |
| out_bit | output | 1 | Serial output data |
| out_sof | output | 1 | Marks the first bit of an outgoing packet |

## Verification
The bench targets four corner cases:
- An add of 0xFFFFFFFF and 1 carries across all 32 positions. A design that loses the carry between positions leaves ones in the result.
- A zero add right after that packet gives a result of zero. A design that never clears its carry sets bit 0 of this result.
- Packets that carry the other function's opcode must come out bit for bit unchanged. A design with a loose opcode compare rewrites their lane A.
- Random valid gaps and ready stalls must not corrupt the stream. A design that releases a lane-A slot before its lane-B partner arrives emits a stale result bit. A design that mishandles stalls drops or repeats bits.

// File: rtl/bsp_pkg.sv
package bsp_pkg;
  localparam int OPC_W = 4;
  localparam logic [OPC_W-1:0] OPC_ADD = 4'h3;
  localparam logic [OPC_W-1:0] OPC_XOR = 4'h6;

  // one stream bit plus the tags the pipeline needs downstream
  typedef struct packed {
    logic data;
    logic sof;
    logic opc;     // bit lies in the opcode field
    logic acc;     // accumulator slot of a packet this element works on
    logic xor_op;  // function applied to that packet
  } beat_t;
endpackage

// File: rtl/bsp_frame_track.sv
module bsp_frame_track
  import bsp_pkg::*;
#(
  parameter int HDR_BITS  = 8,
  parameter int OPND_W    = 32,
  parameter int LANES     = 4,
  parameter int TAIL_BITS = 8
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  take,
  input  logic  bit_i,
  input  logic  sof_i,
  input  logic  func_sel,
  output beat_t beat_o
);
  localparam int LANE_W    = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int OPND_BITS = OPND_W * LANES;
  localparam int PKT_BITS  = HDR_BITS + OPC_W + OPND_BITS + TAIL_BITS;
  localparam int POS_W     = $clog2(PKT_BITS + 1);
  localparam int OPC_LO    = HDR_BITS;
  localparam int OPND_LO   = HDR_BITS + OPC_W;
  localparam int OPND_HI   = OPND_LO + OPND_BITS;

  logic [POS_W-1:0]  pos_q, cur_pos, opnd_off;
  logic [OPC_W-1:0]  opc_q, opc_full, target;
  logic              match_q, match_xor_q;
  logic              in_opc, in_opnd, last_opc;
  logic [LANE_W-1:0] lane;

  always_comb begin
    cur_pos  = sof_i ? '0 : pos_q;
    in_opc   = (cur_pos >= POS_W'(OPC_LO)) && (cur_pos < POS_W'(OPND_LO));
    in_opnd  = (cur_pos >= POS_W'(OPND_LO)) && (cur_pos < POS_W'(OPND_HI));
    last_opc = (cur_pos == POS_W'(OPND_LO - 1));
    opnd_off = cur_pos - POS_W'(OPND_LO);
    lane     = opnd_off[LANE_W-1:0];
    opc_full = {bit_i, opc_q[OPC_W-1:1]};
    target   = func_sel ? OPC_XOR : OPC_ADD;
    beat_o.data   = bit_i;
    beat_o.sof    = sof_i;
    beat_o.opc    = in_opc;
    beat_o.acc    = in_opnd && (lane == '0) && match_q;
    beat_o.xor_op = match_xor_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q       <= POS_W'(PKT_BITS);
      opc_q       <= '0;
      match_q     <= 1'b0;
      match_xor_q <= 1'b0;
    end else if (take) begin
      pos_q <= (cur_pos == POS_W'(PKT_BITS)) ? cur_pos : cur_pos + 1'b1;
      if (in_opc) opc_q <= opc_full;
      if (sof_i) match_q <= 1'b0;
      if (last_opc) begin
        match_q     <= (opc_full == target);
        match_xor_q <= func_sel;
      end
    end
  end
endmodule

// File: rtl/bsp_serial_alu.sv
module bsp_serial_alu (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  input  logic a,
  input  logic b,
  input  logic xor_mode,
  output logic res,
  output logic carry_o
);
  logic carry_q;

  assign res     = xor_mode ? (a ^ b) : (a ^ b ^ carry_q);
  assign carry_o = carry_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) carry_q <= 1'b0;
    else if (clr) carry_q <= 1'b0;
    else if (step && !xor_mode) carry_q <= (a & b) | (a & carry_q) | (b & carry_q);
  end
endmodule

// File: rtl/bsp_accum_elem.sv
module bsp_accum_elem
  import bsp_pkg::*;
#(
  parameter int HDR_BITS  = 8,
  parameter int OPND_W    = 32,
  parameter int LANES     = 4,
  parameter int TAIL_BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic func_sel,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_bit,
  input  logic in_sof,
  output logic out_valid,
  input  logic out_ready,
  output logic out_bit,
  output logic out_sof
);
  beat_t in_beat, s1_q, s2_q;
  logic  s1_v, s2_v;
  logic  in_fire, s1_move, s2_fire, s2_wait;
  logic  alu_res, carry_w, opc_leave;

  assign in_fire = in_valid && in_ready;

  bsp_frame_track #(
    .HDR_BITS (HDR_BITS),
    .OPND_W   (OPND_W),
    .LANES    (LANES),
    .TAIL_BITS(TAIL_BITS)
  ) u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (in_fire),
    .bit_i   (in_bit),
    .sof_i   (in_sof),
    .func_sel(func_sel),
    .beat_o  (in_beat)
  );

  // an accumulator slot may only leave once its lane-B partner sits in stage 1
  assign s2_wait   = s2_v && s2_q.acc && !s1_v;
  assign out_valid = s2_v && !s2_wait;
  assign s2_fire   = out_valid && out_ready;
  assign s1_move   = s1_v && (!s2_v || s2_fire);
  assign in_ready  = !s1_v || s1_move;
  assign opc_leave = s2_fire && s2_q.opc;

  bsp_serial_alu u_alu (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (opc_leave),
    .step    (s2_fire && s2_q.acc),
    .a       (s2_q.data),
    .b       (s1_q.data),
    .xor_mode(s2_q.xor_op),
    .res     (alu_res),
    .carry_o (carry_w)
  );

  assign out_bit = s2_q.acc ? alu_res : s2_q.data;
  assign out_sof = s2_q.sof;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 1'b0;
      s2_v <= 1'b0;
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      if (in_fire) begin
        s1_q <= in_beat;
        s1_v <= 1'b1;
      end else if (s1_move) begin
        s1_v <= 1'b0;
      end
      if (s1_move) begin
        s2_q <= s1_q;
        s2_v <= 1'b1;
      end else if (s2_fire) begin
        s2_v <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bsp_accum_chk.sv
module bsp_accum_chk (
  input logic clk,
  input logic rst_n,
  input logic in_ready,
  input logic out_valid,
  input logic out_ready,
  input logic out_bit,
  input logic out_sof,
  input logic opc_leave,
  input logic carry_now
);
  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!out_valid && in_ready));

  p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit) && $stable(out_sof)));

  p_ready_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (out_valid && !out_ready));

  p_carry_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    opc_leave |=> !carry_now);
endmodule

bind bsp_accum_elem bsp_accum_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_bit  (out_bit),
  .out_sof  (out_sof),
  .opc_leave(opc_leave),
  .carry_now(carry_w)
);

// File: tb/bsp_accum_elem_bench.sv
module bsp_accum_elem_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic func_sel = 1'b0;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  logic in_sof = 1'b0;
  logic out_ready = 1'b0;
  logic in_ready, out_valid, out_bit, out_sof;

  int n_chk = 0;
  int n_bad = 0;

  bit    in_q[$];
  bit    isof_q[$];
  bit    fs_q[$];
  bit    exp_q[$];
  bit    esof_q[$];
  string req_q[$];

  always #10 clk = ~clk;

  bsp_accum_elem u_bsp_accum_elem (
    .clk(clk), .rst_n(rst_n), .func_sel(func_sel),
    .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit), .in_sof(in_sof),
    .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit), .out_sof(out_sof)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_bit(input bit v, input bit sof, input bit fs, input bit ev, input string req);
    in_q.push_back(v); isof_q.push_back(sof); fs_q.push_back(fs);
    exp_q.push_back(ev); esof_q.push_back(sof); req_q.push_back(req);
  endtask

  // one packet: 8 header, 4 opcode LSB first, 4x32 interleaved A,B,C,D, 8 tail
  task automatic add_pkt(input logic [3:0] opc, input bit fs,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] c, input logic [31:0] d, input string areq);
    logic [7:0]  hdr = 8'($urandom);
    logic [7:0]  tl  = 8'($urandom);
    bit          hit = (opc == (fs ? 4'h6 : 4'h3));
    logic [31:0] r   = hit ? (fs ? (a ^ b) : (a + b)) : a;
    string       keep = hit ? "R6" : "R7";
    for (int i = 0; i < 8; i++) push_bit(hdr[i], i == 0, fs, hdr[i], "R2");
    for (int i = 0; i < 4; i++) push_bit(opc[i], 1'b0, fs, opc[i], keep);
    for (int i = 0; i < 32; i++) begin
      push_bit(a[i], 1'b0, fs, r[i], areq);
      push_bit(b[i], 1'b0, fs, b[i], keep);
      push_bit(c[i], 1'b0, fs, c[i], keep);
      push_bit(d[i], 1'b0, fs, d[i], keep);
    end
    for (int i = 0; i < 8; i++) push_bit(tl[i], 1'b0, fs, tl[i], "R2");
  endtask

  // streams all queued bits; rough adds valid gaps and ready stalls,
  // hold forces out_ready low for the first cycles
  task automatic run_stream(input bit rough, input int hold);
    int cyc = 0;
    int taken = 0;
    while (in_q.size() > 0 || exp_q.size() > 0) begin
      @(negedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_chk++; n_bad++;
        $display("FAIL R8 watchdog actual=%0d expected=%0d bits left", exp_q.size(), 0);
        in_q.delete(); isof_q.delete(); fs_q.delete();
        exp_q.delete(); esof_q.delete(); req_q.delete();
        in_valid = 1'b0;
        break;
      end
      out_ready = (cyc <= hold) ? 1'b0 : (rough ? ($urandom % 3 != 0) : 1'b1);
      if (in_q.size() > 0 && (!rough || $urandom % 4 != 0)) begin
        in_valid = 1'b1; in_bit = in_q[0]; in_sof = isof_q[0]; func_sel = fs_q[0];
      end else begin
        in_valid = 1'b0; in_sof = 1'b0;
      end
      #1;
      if (in_valid && in_ready) begin
        void'(in_q.pop_front()); void'(isof_q.pop_front()); void'(fs_q.pop_front());
        if (cyc <= hold) taken++;
      end
      if (hold > 0 && cyc == hold) check("R8 bits taken during stall", taken, 2);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check("R8 extra output bit", 1, 0);
        end else begin
          string rq = req_q.pop_front();
          bit ev = exp_q.pop_front();
          bit es = esof_q.pop_front();
          check(rq, out_bit, ev);
          check("R2 sof", out_sof, es);
        end
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", out_valid, 0);
    check("R1 in_ready in reset", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid after reset", out_valid, 0);
    check("R1 in_ready after reset", in_ready, 1);

    // smooth stream with an initial stall
    add_pkt(4'h3, 1'b0, 32'hFFFF_FFFF, 32'h0000_0001, 32'h1234_5678, 32'h9ABC_DEF0, "R3");
    add_pkt(4'h3, 1'b0, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R5");
    add_pkt(4'h6, 1'b1, 32'hA5A5_0F0F, 32'hFFFF_0000, 32'h0, 32'h1, "R4");
    add_pkt(4'h6, 1'b0, 32'hDEAD_BEEF, 32'h1111_1111, 32'h2, 32'h3, "R7");
    add_pkt(4'h3, 1'b1, 32'hCAFE_F00D, 32'h0BAD_0BAD, 32'h4, 32'h5, "R7");
    add_pkt(4'h0, 1'b0, 32'h8000_0000, 32'h8000_0000, 32'h6, 32'h7, "R7");
    run_stream(1'b0, 6);

    // rough stream: gaps and stalls, mixed functions and opcodes
    add_pkt(4'h3, 1'b0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h0, 32'h0, "R3");
    add_pkt(4'h3, 1'b0, 32'h0, 32'h0, 32'h0, 32'h0, "R5");
    for (int k = 0; k < 10; k++) begin
      bit          fs  = 1'($urandom);
      logic [3:0]  opc = (k % 3 == 2) ? 4'($urandom) : (fs ? 4'h6 : 4'h3);
      string       rq  = (opc != (fs ? 4'h6 : 4'h3)) ? "R7" : (fs ? "R4" : "R3");
      add_pkt(opc, fs, $urandom, $urandom, $urandom, $urandom, rq);
    end
    run_stream(1'b1, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule